// File: doc/BRIEF.md
# Serial Wiper Register Interface

This block is a three-wire serial slave that owns four 8-bit wiper setting registers. A host raises the select line and clocks in frames on the serial input: a leading 1 marks the start of a frame, then a 2-bit channel number, then an 8-bit setting. Both the channel number and the setting are sent least significant bit first. While the new setting is clocked in, the old contents of the chosen register are clocked out on the serial output. Every read is therefore destructive, and a read with no change is a frame that the host cuts short.

Written values are temporary. They hold only while select stays high. When select goes low, every register reloads from a vector of stored values supplied at the block's edge, and the output enable drops. The serial output is modelled as a data bit plus an enable, so the surrounding logic can build the tri-state pad.

Top module: `serial_wiper_ctrl`

## Requirements
- R1: While reset is high and on the cycle after it, every wiper output equals its slice of `stored_vals` (channel n in bits 8n+7..8n) and `sdo_oe` is low.
- R2: With select high and no frame in progress, a 0 on `sdi` starts nothing: `sdo_oe` stays low and the wipers keep their values. A 1 sampled on a rising edge is a start bit.
- R3: The two bits after the start bit form the channel number, low bit first. The value {second,first} = 0, 1, 2, 3 selects channel 0, 1, 2, 3.
- R4: After the edge that samples the second channel bit, `sdo_oe` is high for exactly 8 cycles. During those cycles `sdo` shows the old contents of the chosen channel, bit 0 first, advancing one bit per rising edge.
- R5: The 8 data bits arrive bit 0 first. The chosen wiper holds its old value up to and including the edge that samples data bit 7, and shows the new value from the cycle after it. No other wiper changes.
- R6: The two cycles after data bit 7 ignore `sdi`. A 1 in either of them does not start a frame.
- R7: With select low, every wiper follows `stored_vals` from the next cycle on and `sdo_oe` is low.
- R8: Dropping select before data bit 7 has been sampled commits nothing and leaves the chosen wiper at its stored value. The next frame starts fresh from a start bit.
- R9: Temporary values written to several channels in any order all persist while select stays high.
- R10: If select is low at the edge where data bit 7 would be sampled, the restore wins and the chosen wiper ends at its stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; all sampling on rising edges |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Select; high enables frames, low restores all wipers |
| sdi | input | 1 | Serial data in |
| stored_vals | input | 32 | Stored setting per channel, channel n in bits 8n+7..8n |
| sdo | output | 1 | Serial readback bit (0 when not enabled) |
| sdo_oe | output | 1 | Enable for the serial output pad |
| wiper_vals | output | 32 | Current wiper settings, same packing as `stored_vals` |

## Verification
Two functions can land on the same edge: the commit of a finished frame and the restore caused by select going low. The bench provokes this by lowering select on the very cycle in which data bit 7 is presented. It then judges the result at the ports: the chosen wiper must show the stored value and no partial readback word may be scored. A second collision happens inside the gap after a frame, where a 1 on the data line must not be taken as a start bit. The bench proves this by watching the output enable stay low over the following cycles.

// File: rtl/wiper_pkg.sv
package wiper_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2,
        PH_GAP  = 2'd3
    } phase_e;

    typedef struct packed {
        logic load;    // capture old register contents for readback
        logic shift;   // advance readback, data phase active
        logic commit;  // last data bit present on sdi this cycle
    } frame_ctl_t;

    function automatic int unsigned idx_w(int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

    function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/wiper_frame_seq.sv
module wiper_frame_seq
    import wiper_pkg::*;
#(
    parameter int unsigned NCH = 4,
    parameter int unsigned WW  = 8,
    parameter int unsigned GAP = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     sel,
    input  logic                     sdi,
    output frame_ctl_t               ctl,
    output logic [idx_w(NCH)-1:0]    addr_next,
    output logic [idx_w(NCH)-1:0]    addr_q,
    output logic [WW-1:0]            data_next
);
    localparam int unsigned AW = idx_w(NCH);
    localparam int unsigned CW = idx_w(max3(AW, WW, GAP) + 1);

    phase_e          phase;
    logic [CW-1:0]   cnt;
    logic [AW-1:0]   addr_sr;
    logic [WW-1:0]   data_sr;
    logic            active;

    assign active = sel && !rst;

    generate
        if (AW > 1) begin : g_addr_wide
            assign addr_next = {sdi, addr_sr[AW-1:1]};
        end else begin : g_addr_narrow
            assign addr_next = sdi;
        end
    endgenerate

    assign data_next = {sdi, data_sr[WW-1:1]};
    assign addr_q    = addr_sr;

    always_comb begin
        ctl        = '0;
        ctl.load   = active && (phase == PH_ADDR) && (cnt == CW'(AW - 1));
        ctl.shift  = active && (phase == PH_DATA);
        ctl.commit = active && (phase == PH_DATA) && (cnt == CW'(WW - 1));
    end

    always_ff @(posedge clk) begin
        if (rst || !sel) begin
            phase   <= PH_IDLE;
            cnt     <= '0;
            addr_sr <= '0;
            data_sr <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (sdi) begin
                        phase <= PH_ADDR;
                        cnt   <= '0;
                    end
                end
                PH_ADDR: begin
                    addr_sr <= addr_next;
                    if (cnt == CW'(AW - 1)) begin
                        phase <= PH_DATA;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_DATA: begin
                    data_sr <= data_next;
                    if (cnt == CW'(WW - 1)) begin
                        phase <= (GAP == 0) ? PH_IDLE : PH_GAP;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_GAP: begin
                    if (cnt >= CW'(GAP - 1)) begin
                        phase <= PH_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/wiper_readback.sv
module wiper_readback
    import wiper_pkg::*;
#(
    parameter int unsigned WW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sel,
    input  frame_ctl_t      ctl,
    input  logic [WW-1:0]   old_word,
    output logic            sdo,
    output logic            sdo_oe
);
    logic [WW-1:0] rb_sr;

    always_ff @(posedge clk) begin
        if (rst || !sel) begin
            rb_sr <= '0;
        end else if (ctl.load) begin
            rb_sr <= old_word;
        end else if (ctl.shift) begin
            rb_sr <= {1'b0, rb_sr[WW-1:1]};
        end
    end

    assign sdo_oe = ctl.shift;
    assign sdo    = ctl.shift ? rb_sr[0] : 1'b0;

endmodule

// File: rtl/wiper_bank.sv
module wiper_bank
    import wiper_pkg::*;
#(
    parameter int unsigned NCH = 4,
    parameter int unsigned WW  = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    sel,
    input  logic                    commit,
    input  logic [idx_w(NCH)-1:0]   waddr,
    input  logic [WW-1:0]           wdata,
    input  logic [NCH*WW-1:0]       stored_vals,
    output logic [NCH*WW-1:0]       wiper_vals
);
    genvar gi;
    generate
        for (gi = 0; gi < NCH; gi++) begin : g_ch
            logic [WW-1:0] w_q;
            always_ff @(posedge clk) begin
                if (rst || !sel) begin
                    w_q <= stored_vals[gi*WW +: WW];
                end else if (commit && (int'(waddr) == gi)) begin
                    w_q <= wdata;
                end
            end
            assign wiper_vals[gi*WW +: WW] = w_q;
        end
    endgenerate

endmodule

// File: rtl/serial_wiper_ctrl.sv
module serial_wiper_ctrl
    import wiper_pkg::*;
#(
    parameter int unsigned NCH = 4,
    parameter int unsigned WW  = 8,
    parameter int unsigned GAP = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sel,
    input  logic                sdi,
    input  logic [NCH*WW-1:0]   stored_vals,
    output logic                sdo,
    output logic                sdo_oe,
    output logic [NCH*WW-1:0]   wiper_vals
);
    localparam int unsigned AW = idx_w(NCH);

    frame_ctl_t       ctl;
    logic [AW-1:0]    addr_next;
    logic [AW-1:0]    addr_q;
    logic [WW-1:0]    data_next;
    logic [WW-1:0]    old_word;

    wiper_frame_seq #(.NCH(NCH), .WW(WW), .GAP(GAP)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .sel       (sel),
        .sdi       (sdi),
        .ctl       (ctl),
        .addr_next (addr_next),
        .addr_q    (addr_q),
        .data_next (data_next)
    );

    always_comb begin
        old_word = '0;
        for (int i = 0; i < NCH; i++) begin
            if (int'(addr_next) == i) old_word = wiper_vals[i*WW +: WW];
        end
    end

    wiper_readback #(.WW(WW)) u_rb (
        .clk      (clk),
        .rst      (rst),
        .sel      (sel),
        .ctl      (ctl),
        .old_word (old_word),
        .sdo      (sdo),
        .sdo_oe   (sdo_oe)
    );

    wiper_bank #(.NCH(NCH), .WW(WW)) u_bank (
        .clk         (clk),
        .rst         (rst),
        .sel         (sel),
        .commit      (ctl.commit),
        .waddr       (addr_q),
        .wdata       (data_next),
        .stored_vals (stored_vals),
        .wiper_vals  (wiper_vals)
    );

endmodule

// File: rtl/serial_wiper_ctrl_chk.sv
module serial_wiper_ctrl_chk #(
    parameter int unsigned NCH = 4,
    parameter int unsigned WW  = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                sel,
    input logic                sdo_oe,
    input logic [NCH*WW-1:0]   stored_vals,
    input logic [NCH*WW-1:0]   wiper_vals
);
    logic [NCH*WW-1:0] prev_w;
    logic              prev_live;
    logic [NCH-1:0]    chg;
    int unsigned       oe_run;

    always_ff @(posedge clk) begin
        prev_w    <= wiper_vals;
        prev_live <= sel && !rst;
        oe_run    <= sdo_oe ? oe_run + 1 : 0;
    end

    always_comb begin
        for (int i = 0; i < NCH; i++) chg[i] = (wiper_vals[i*WW +: WW] != prev_w[i*WW +: WW]);
    end

    p_reset_load_r1: assert property (@(posedge clk) rst |=> (wiper_vals == $past(stored_vals)));
    p_restore_r7:    assert property (@(posedge clk) disable iff (rst) !sel |=> (wiper_vals == $past(stored_vals)));
    p_oe_off_r7:     assert property (@(posedge clk) disable iff (rst) !sel |-> !sdo_oe);
    p_oe_len_r4:     assert property (@(posedge clk) disable iff (rst) oe_run <= WW);
    p_one_chan_r5:   assert property (@(posedge clk) disable iff (rst) (sel && prev_live) |-> ($countones(chg) <= 1));
    p_gap_r6:        assert property (@(posedge clk) disable iff (rst) (sel && $fell(sdo_oe)) |=> !sdo_oe);

endmodule

bind serial_wiper_ctrl serial_wiper_ctrl_chk #(.NCH(NCH), .WW(WW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .sel         (sel),
    .sdo_oe      (sdo_oe),
    .stored_vals (stored_vals),
    .wiper_vals  (wiper_vals)
);

// File: tb/test_serial_wiper_ctrl.sv
module test_serial_wiper_ctrl;
    localparam int NCH = 4;
    localparam int WW  = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sel = 1'b0;
    logic sdi = 1'b0;
    logic [NCH*WW-1:0] stored_vals = 32'h3C81_5A17;
    logic sdo, sdo_oe;
    logic [NCH*WW-1:0] wiper_vals;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    logic [WW-1:0] rb_q[$];
    logic [WW-1:0] model[NCH];

    always #5 clk = ~clk;

    serial_wiper_ctrl i_serial_wiper_ctrl (
        .clk(clk), .rst(rst), .sel(sel), .sdi(sdi),
        .stored_vals(stored_vals), .sdo(sdo), .sdo_oe(sdo_oe), .wiper_vals(wiper_vals)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [WW-1:0] wv(int c);
        return wiper_vals[c*WW +: WW];
    endfunction

    task automatic drive(logic s, logic b);
        @(negedge clk);
        sel = s;
        sdi = b;
    endtask

    task automatic restore_model();
        for (int c = 0; c < NCH; c++) model[c] = stored_vals[c*WW +: WW];
    endtask

    task automatic check_all(string req);
        for (int c = 0; c < NCH; c++) check(req, wv(c), model[c]);
    endtask

    // full frame; gap bits are what sdi carries in the two cycles after D7
    task automatic frame(int ch, logic [WW-1:0] v, logic gapbit);
        rb_q.push_back(model[ch]);
        drive(1, 1);
        drive(1, ch[0]);
        drive(1, ch[1]);
        for (int i = 0; i < WW; i++) drive(1, v[i]);
        check("R5 hold before commit", wv(ch), model[ch]);
        drive(1, gapbit);
        model[ch] = v;
        check_all("R3/R5 commit to addressed channel");
        drive(1, gapbit);
    endtask

    // scoreboard monitor: collects readback words and compares with queue
    initial begin
        logic [WW-1:0] word;
        int n;
        n = 0;
        word = '0;
        forever begin
            @(negedge clk);
            #2;
            if (sdo_oe) begin
                word[n] = sdo;
                n++;
                if (n == WW) begin
                    if (rb_q.size() == 0) check("R4 unexpected readback", word, 32'hFFFF_FFFF);
                    else check("R4 readback word", word, rb_q.pop_front());
                    n = 0;
                end
            end else begin
                n = 0;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog all-requirements act=timeout exp=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        restore_model();
        repeat (3) @(negedge clk);
        check("R1 reset wipers", wiper_vals, stored_vals);
        check("R1 reset oe", sdo_oe, 0);
        drive(0, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset", wiper_vals, stored_vals);

        // R2: idle zeros ignored
        for (int i = 0; i < 5; i++) begin
            drive(1, 0);
            check("R2 idle oe", sdo_oe, 0);
        end
        check("R2 idle wipers", wiper_vals, stored_vals);

        // R3/R4/R5: frames on every channel, in mixed order
        frame(2, 8'hA5, 0);
        frame(0, 8'hC3, 0);
        frame(3, 8'h0F, 0);
        frame(1, 8'hF0, 0);
        frame(2, 8'h66, 0);

        // R6: ones in the gap are not start bits
        frame(1, 8'h99, 1);
        for (int i = 0; i < 4; i++) begin
            drive(1, 0);
            check("R6 gap ones ignored oe", sdo_oe, 0);
        end
        check_all("R6 gap ones ignored wipers");

        // R9: all temporary values persist
        repeat (3) drive(1, 0);
        check_all("R9 persistence");

        // R7: select low restores
        drive(0, 0);
        restore_model();
        @(negedge clk);
        check("R7 restore wipers", wiper_vals, stored_vals);
        check("R7 oe low", sdo_oe, 0);

        // R8: abort mid-data
        drive(1, 0);
        drive(1, 1);
        drive(1, 0);
        drive(1, 1);
        for (int i = 0; i < 4; i++) drive(1, 1);
        drive(0, 0);
        @(negedge clk);
        check("R8 abort no commit", wv(2), stored_vals[2*WW +: WW]);
        check("R8 abort oe", sdo_oe, 0);
        drive(1, 0);
        frame(2, 8'h42, 0);

        // R7: stored value change while select low is followed
        drive(0, 0);
        stored_vals[7:0] = 8'h99;
        restore_model();
        @(negedge clk);
        @(negedge clk);
        check("R7 follows stored", wiper_vals, stored_vals);

        // R10: select drops on the cycle of D7
        drive(1, 0);
        drive(1, 1);
        drive(1, 1);
        drive(1, 0);
        for (int i = 0; i < WW - 1; i++) drive(1, 1'b1);
        drive(0, 1);
        @(negedge clk);
        check("R10 restore beats commit", wv(1), stored_vals[1*WW +: WW]);
        check("R10 oe", sdo_oe, 0);
        @(negedge clk);
        check("R10 all restored", wiper_vals, stored_vals);
        check("R4 no pending readback", rb_q.size(), 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule